// File: doc/BRIEF.md
# I2C Slave with Strobe Interface

This block connects a two-wire serial bus to a passive target such as a register file or a small memory. It runs entirely on one system clock and samples the bus clock and data lines as ordinary inputs. Each line passes through a synchroniser and a stable-count spike filter. The block then detects start, repeated-start and stop conditions. It compares a received 7-bit address against a fixed, build-time address and acts as a receiver or a transmitter, whichever the bus master requests.

The block pulls the data line low by driving `sda_out` low. It has no tri-state logic. Toward the target it presents two buses and two strobes:

- Each received data byte appears on `rx_byte` together with a one-clock `wr_stb` pulse.
- Each byte to be sent is requested with a one-clock `rd_stb` pulse and taken from `tx_byte` on the next clock.

The block needs no setup and works as soon as reset is released. Single transfers, multi-byte bursts in either direction and repeated starts all work without outside help.

Top module: `i2c_strobe_slave`

## Requirements
- R1: After reset, `sda_out` is 1, `rd_stb` and `wr_stb` are 0 and `rx_byte` is 0.
- R2: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks (after two synchroniser flops) has no effect on address, data, start or stop detection.
- R3: After a start, the first byte is taken MSB first. Bits 7..1 are the address and bit 0 is the direction (1 = slave transmits, 0 = slave receives). On an address match, `sda_out` is 0 during the ninth bus clock.
- R4: On an address mismatch, `sda_out` stays 1 and no strobe is issued until the next start, whatever traffic follows.
- R5: In receive mode every data byte is acknowledged by driving `sda_out` 0 during its ninth bus clock. A one-clock `wr_stb` pulse is issued after the eighth bit, with `rx_byte` holding the byte (first bit received = bit 7). Any number of bytes can follow one address.
- R6: In transmit mode a one-clock `rd_stb` pulse precedes each byte, and `tx_byte` is captured on the next clock. Bits go out MSB first on `sda_out` and change only while SCL is low. A master acknowledge (SDA low on the ninth clock) requests another byte.
- R7: A master not-acknowledge ends the read. `sda_out` then stays 1 and no further `rd_stb` is issued until a start or stop.
- R8: A start seen part-way through a byte abandons that byte, issuing no strobe for it, and begins address reception again.
- R9: A stop (SDA rising while SCL is high) returns the block to idle with `sda_out` at 1.
- R10: Address bytes never produce `wr_stb` or `rd_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_out | output | 1 | Data line drive; 0 pulls the line low, 1 releases it |
| rd_stb | output | 1 | One-clock request for the next byte to transmit |
| wr_stb | output | 1 | One-clock strobe marking a received byte |
| rx_byte | output | 8 | Last received data byte |
| tx_byte | input | 8 | Byte from the target, captured one clock after `rd_stb` |

## Verification
The hardest situations to reach are a repeated start that cuts a byte off half-way, and a short spike that would look like a start or an extra clock edge if it got past the filter. The bench master clocks four data bits, lifts SDA while SCL is still low, and then issues a new start straight into a read. It injects SDA and SCL pulses shorter than the filter window in the middle of SCL-high phases of a written byte. In both cases the bench confirms that the byte queue, the strobe counts and the per-clock `sda_out` model still agree.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX_LOAD,
        ST_TX,
        ST_TX_ACK
    } slv_state_e;

    typedef struct packed {
        slv_state_e  state;
        logic [3:0]  cnt;
        logic [7:0]  shreg;
        logic        dir_rd;
        logic        master_ack;
        logic        sda_out;
        logic        rd;
        logic        wr;
        logic [7:0]  rx;
    } slv_regs_t;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          level;
    } filt_regs_t;

    filt_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        r_d.sync = {r_q.sync[0], raw};
        if (r_q.sync[1] == r_q.level) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(FILT_LEN - 1)) begin
            r_d.level = r_q.sync[1];
            r_d.cnt   = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{sync: 2'b11, cnt: '0, level: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign level = r_q.level;

    // R2
    filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.level != $past(r_q.level)) |-> (r_q.level == $past(r_q.sync[1])));

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_regs_t;

    prev_regs_t p_q, p_d;

    always_comb begin
        p_d.scl = scl_f;
        p_d.sda = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            p_q <= p_d;
        end
    end

    assign ev_rise  = scl_f & ~p_q.scl;
    assign ev_fall  = ~scl_f & p_q.scl;
    assign ev_start = scl_f & p_q.scl & p_q.sda & ~sda_f;
    assign ev_stop  = scl_f & p_q.scl & ~p_q.sda & sda_f;

endmodule

// File: rtl/i2c_strobe_slave.sv
module i2c_strobe_slave #(
    parameter logic [6:0] SLAVE_ADDR = 7'h2C,
    parameter int         FILT_LEN   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_out,
    output logic       rd_stb,
    output logic       wr_stb,
    output logic [7:0] rx_byte,
    input  logic [7:0] tx_byte
);
    import i2cs_pkg::*;

    localparam int NLINES = 2;
    localparam int SCL_IX = 1;
    localparam int SDA_IX = 0;

    logic [NLINES-1:0] line_raw;
    logic [NLINES-1:0] line_f;
    logic scl_f, sda_f;
    logic ev_rise, ev_fall, ev_start, ev_stop;

    assign line_raw = {scl_in, sda_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2cs_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (line_raw[g]),
            .level (line_f[g])
        );
    end

    assign scl_f = line_f[SCL_IX];
    assign sda_f = line_f[SDA_IX];

    i2cs_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    slv_regs_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.rd = 1'b0;
        r_d.wr = 1'b0;
        if (ev_start) begin
            r_d.state   = ST_ADDR;
            r_d.cnt     = '0;
            r_d.sda_out = 1'b1;
        end else if (ev_stop) begin
            r_d.state   = ST_IDLE;
            r_d.sda_out = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_IDLE: ;
                ST_ADDR, ST_RX: begin
                    if (ev_rise && r_q.cnt < 4'd8) begin
                        r_d.shreg = {r_q.shreg[6:0], sda_f};
                        r_d.cnt   = r_q.cnt + 4'd1;
                    end else if (ev_fall && r_q.cnt == 4'd8) begin
                        if (r_q.state == ST_RX) begin
                            r_d.wr      = 1'b1;
                            r_d.rx      = r_q.shreg;
                            r_d.sda_out = 1'b0;
                            r_d.state   = ST_RX_ACK;
                        end else if (r_q.shreg[7:1] == SLAVE_ADDR) begin
                            r_d.dir_rd  = r_q.shreg[0];
                            r_d.sda_out = 1'b0;
                            r_d.state   = ST_ADDR_ACK;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev_fall) begin
                        if (r_q.dir_rd) begin
                            r_d.rd    = 1'b1;
                            r_d.state = ST_TX_LOAD;
                        end else begin
                            r_d.sda_out = 1'b1;
                            r_d.cnt     = '0;
                            r_d.state   = ST_RX;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (ev_fall) begin
                        r_d.sda_out = 1'b1;
                        r_d.cnt     = '0;
                        r_d.state   = ST_RX;
                    end
                end
                ST_TX_LOAD: begin
                    r_d.shreg   = tx_byte;
                    r_d.sda_out = tx_byte[7];
                    r_d.cnt     = '0;
                    r_d.state   = ST_TX;
                end
                ST_TX: begin
                    if (ev_fall) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.sda_out = 1'b1;
                            r_d.state   = ST_TX_ACK;
                        end else begin
                            r_d.sda_out = r_q.shreg[6];
                            r_d.shreg   = {r_q.shreg[6:0], 1'b0};
                            r_d.cnt     = r_q.cnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev_rise) begin
                        r_d.master_ack = ~sda_f;
                    end else if (ev_fall) begin
                        if (r_q.master_ack) begin
                            r_d.rd    = 1'b1;
                            r_d.state = ST_TX_LOAD;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, shreg: '0, dir_rd: 1'b0,
                     master_ack: 1'b0, sda_out: 1'b1, rd: 1'b0, wr: 1'b0,
                     rx: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_out = r_q.sda_out;
    assign rd_stb  = r_q.rd;
    assign wr_stb  = r_q.wr;
    assign rx_byte = r_q.rx;

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    // R6
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_out != $past(sda_out)) |-> !$past(scl_f));

    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> sda_out);

    // R10
    addr_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ADDR_ACK && $past(r_q.state) == ST_ADDR) |-> (!wr_stb && !rd_stb));

endmodule

// File: tb/test_i2c_strobe_slave.sv
module test_i2c_strobe_slave;

    localparam logic [6:0] ADDR = 7'h2C;
    localparam int FILT   = 4;
    localparam int H      = 40;
    localparam int SETTLE = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, sda_g = 1'b1;
    logic sda_out, rd_stb, wr_stb;
    logic [7:0] rx_byte, tx_byte;
    logic sda_line;

    always #2 clk = ~clk;

    assign sda_line = sda_m & sda_g & sda_out;

    i2c_strobe_slave #(.SLAVE_ADDR(ADDR), .FILT_LEN(FILT)) i_i2c_strobe_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_out(sda_out), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .rx_byte(rx_byte), .tx_byte(tx_byte)
    );

    int vecs = 0;
    int errs = 0;
    string cur_req = "R1";
    logic chk_en = 1'b0;
    logic exp_sda = 1'b1;
    logic [7:0] wq[$];
    logic [7:0] mem [4] = '{8'hA7, 8'h3C, 8'h01, 8'h80};
    int ptr = 0;
    bit ptr_pend = 1'b0;
    bit rd_prev = 1'b0;
    int rd_cnt = 0;
    int exp_rd = 0;

    assign tx_byte = mem[ptr % 4];

    task automatic check(input string req, input int got, input int exp);
        vecs++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_en) check({cur_req, " sda_out"}, int'(sda_out), int'(exp_sda));
            if (wr_stb) begin
                if (wq.size() == 0) check("R10 unexpected wr_stb", 1, 0);
                else check("R5 rx_byte at wr_stb", int'(rx_byte), int'(wq.pop_front()));
            end
            if (rd_stb && rd_prev) check("R6 rd_stb width", 2, 1);
            if (ptr_pend) begin ptr++; ptr_pend = 1'b0; end
            if (rd_stb) begin rd_cnt++; ptr_pend = 1'b1; end
            rd_prev = rd_stb;
        end
    end

    task automatic clk_bit(input logic mb, input logic exp, input bit glitch, output logic got);
        chk_en = 1'b0;
        sda_m  = mb;
        repeat (SETTLE) @(negedge clk);
        exp_sda = exp;
        chk_en  = 1'b1;
        repeat (H - SETTLE) @(negedge clk);
        scl_m = 1'b1;
        repeat (H / 2) @(negedge clk);
        if (glitch) begin
            sda_g = 1'b0;
            repeat (FILT - 2) @(negedge clk);
            sda_g = 1'b1;
            repeat (8) @(negedge clk);
            scl_m = 1'b0;
            repeat (FILT - 2) @(negedge clk);
            scl_m = 1'b1;
        end
        repeat (H / 2) @(negedge clk);
        got   = sda_line;
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        chk_en = 1'b0;
        sda_m  = 1'b1;
        repeat (SETTLE) @(negedge clk);
        exp_sda = 1'b1;
        chk_en  = 1'b1;
        repeat (H - SETTLE) @(negedge clk);
        scl_m = 1'b1;
        repeat (H) @(negedge clk);
        sda_m = 1'b0;
        repeat (H) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        chk_en = 1'b0;
        sda_m  = 1'b0;
        repeat (SETTLE) @(negedge clk);
        exp_sda = 1'b1;
        chk_en  = 1'b1;
        repeat (H - SETTLE) @(negedge clk);
        scl_m = 1'b1;
        repeat (H) @(negedge clk);
        sda_m = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit acked, input bit push, input bit glitch);
        logic got;
        if (push) wq.push_back(b);
        for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b1, glitch, got);
        clk_bit(1'b1, !acked, 1'b0, got);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit mack);
        logic got;
        for (int i = 7; i >= 0; i--) clk_bit(1'b1, exp[i], 1'b0, got);
        clk_bit(!mack, 1'b1, 1'b0, got);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin : main
        logic got;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 sda_out", int'(sda_out), 1);
        check("R1 rd_stb", int'(rd_stb), 0);
        check("R1 wr_stb", int'(wr_stb), 0);
        check("R1 rx_byte", int'(rx_byte), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R3 R5 R9 R10: burst write of three bytes
        cur_req = "R5";
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, 1'b0);
        send_byte(8'h5A, 1'b1, 1'b1, 1'b0);
        send_byte(8'hC3, 1'b1, 1'b1, 1'b0);
        send_byte(8'h00, 1'b1, 1'b1, 1'b0);
        cur_req = "R9";
        bus_stop();
        check("R5 bytes left in queue", wq.size(), 0);

        // R4: mismatched address, traffic ignored
        cur_req = "R4";
        bus_start();
        send_byte({7'h13, 1'b0}, 1'b0, 1'b0, 1'b0);
        send_byte({ADDR, 1'b0}, 1'b0, 1'b0, 1'b0);
        send_byte(8'hFF, 1'b0, 1'b0, 1'b0);
        bus_stop();
        bus_start();
        send_byte({7'h2D, 1'b1}, 1'b0, 1'b0, 1'b0);
        recv_byte(8'hFF, 1'b1);
        bus_stop();
        check("R4 rd strobes after mismatch", rd_cnt, exp_rd);

        // R6 R7: burst read, ack, ack, nack
        cur_req = "R6";
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b1, 1'b0, 1'b0);
        recv_byte(mem[0], 1'b1);
        recv_byte(mem[1], 1'b1);
        recv_byte(mem[2], 1'b0);
        exp_rd += 3;
        check("R6 rd strobe count", rd_cnt, exp_rd);
        cur_req = "R7";
        for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b1, 1'b0, got);
        check("R7 no rd after nack", rd_cnt, exp_rd);
        bus_stop();

        // R8: repeated start cuts a byte, then read
        cur_req = "R8";
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, 1'b0);
        send_byte(8'h96, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, 1'b1, 1'b0, got);
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b1, 1'b0, 1'b0);
        recv_byte(mem[3], 1'b0);
        exp_rd += 1;
        bus_stop();
        check("R8 rd strobe count", rd_cnt, exp_rd);
        check("R8 bytes left in queue", wq.size(), 0);

        // R2: spikes on SDA and SCL inside the high phases
        cur_req = "R2";
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, 1'b1);
        send_byte(8'hB5, 1'b1, 1'b1, 1'b1);
        send_byte(8'h7E, 1'b1, 1'b1, 1'b0);
        bus_stop();
        check("R2 bytes left in queue", wq.size(), 0);
        check("R2 rd strobe count", rd_cnt, exp_rd);

        chk_en = 1'b0;
        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule